// File: doc/BRIEF.md
# Super-I/O Keyed Configuration Port

This block is the configuration front end of a Super-I/O style controller. The host sees only two byte-wide I/O locations: an index port at the base address and a data port one above it. To touch any register, the host first writes the index of the register to the index port and then reads or writes the byte at the data port. The whole space is closed after reset. It opens only when a fixed key byte arrives at the index port on two index writes in a row. It closes again when a close key is written there.

When open, the space is split in two. The indices below 0x30 are global: a logical-device number register at 0x07, and read-only identification bytes for the device, its revision and its maker. The indices from 0x30 up belong to one logical device at a time, picked by the device number. Each device bank holds an activation bit and a 16-bit I/O base address. These drive the matching outputs of the block, and the logical devices themselves use them. A strap input picks which of two base addresses the ports respond at. The bus cycles are decoded outside the block and arrive here as single-cycle read and write strobes with an address.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is closed, every device activation bit is 0, every device base address is 0x0000, the device number is 0 and the index latch holds 0x00.
- R2: The space opens only after the byte 0x87 is written to the index port on two index-port writes in a row. Any other byte written to the index port between them cancels the first one. Writes and reads at other addresses, including the data port, do not disturb the key matcher. The writes that make up the key do not load the index latch.
- R3: While the space is closed, data-port writes change no register, and reads of both the index port and the data port return 0xFF.
- R4: While the space is open, writing 0xAA to the index port closes the space on the next clock edge, and the index latch keeps its value. Any other byte written to the index port is loaded into the index latch.
- R5: The index port is at 0x002E when the strap input is 0 and at 0x004E when it is 1. The data port is one address above the index port. Accesses at any other address are ignored, and reads there return 0xFF.
- R6: The identification registers are read-only. Index 0x20 returns the high byte of the device ID and 0x21 its low byte. Index 0x22 returns the revision. Index 0x23 returns the high byte of the maker ID and 0x24 its low byte.
- R7: Index 0x07 is a read/write device-number register. Its value picks which device bank answers at indices 0x30 and above, and each bank keeps its own contents.
- R8: In the selected bank, bit 0 of index 0x30 is the activation bit of that device and drives bit n of the activation output for device n. The other bits read as 0.
- R9: In the selected bank, index 0x60 holds the high byte and 0x61 the low byte of the 16-bit device base address, which appears on bits 16n+15 down to 16n of the base-address output.
- R10: Indices below 0x30 answer the same whatever the device number is. Unimplemented indices read as 0x00. When the device number is not below the device count, the bank indices read 0x00 and writes to them change nothing.
- R11: While the space is open, a read of the index port returns the current contents of the index latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_sel | input | 1 | Base address strap: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte |
| dev_enable | output | NUM_DEV | Activation bit of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device, device 0 in the low bits |

## Verification
The assertions take for granted that the strap input does not change while the block is out of reset. They also take for granted that a read strobe and a write strobe are never raised in the same cycle, and that the address and write byte are steady for the whole cycle in which a strobe is high. The stimulus keeps to these rules. Each access is a single strobe driven on the falling clock edge and dropped one cycle later. The strap is changed only while reset is asserted, and it is followed by a fresh reset release.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IOA_W  = 16;

  // key bytes seen at the index port
  localparam logic [BYTE_W-1:0] KEY_OPEN  = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_CLOSE = 8'hAA;

  // port locations selected by the strap
  localparam logic [IOA_W-1:0] PORT_LOW  = 16'h002E;
  localparam logic [IOA_W-1:0] PORT_HIGH = 16'h004E;

  // register indices
  localparam logic [BYTE_W-1:0] IX_DEVNUM  = 8'h07;
  localparam logic [BYTE_W-1:0] IX_CHIP_HI = 8'h20;
  localparam logic [BYTE_W-1:0] IX_CHIP_LO = 8'h21;
  localparam logic [BYTE_W-1:0] IX_REV     = 8'h22;
  localparam logic [BYTE_W-1:0] IX_MAKER_HI = 8'h23;
  localparam logic [BYTE_W-1:0] IX_MAKER_LO = 8'h24;
  localparam logic [BYTE_W-1:0] IX_BANK_LO = 8'h30;
  localparam logic [BYTE_W-1:0] IX_ACT     = 8'h30;
  localparam logic [BYTE_W-1:0] IX_IOB_HI  = 8'h60;
  localparam logic [BYTE_W-1:0] IX_IOB_LO  = 8'h61;

  localparam logic [BYTE_W-1:0] FLOAT_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    KS_CLOSED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  typedef struct packed {
    logic              wr;
    logic [BYTE_W-1:0] idx;
    logic [BYTE_W-1:0] data;
  } cfg_wr_t;

  function automatic logic [IOA_W-1:0] port_base(input logic strap);
    return strap ? PORT_HIGH : PORT_LOW;
  endfunction

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ixp_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              open_o,
  output logic [BYTE_W-1:0] index_o
);

  key_state_e        st_q, st_d;
  logic [BYTE_W-1:0] index_q, index_d;
  logic              index_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      KS_CLOSED: if (ixp_wr_i && (wdata_i == KEY_OPEN)) st_d = KS_HALF;
      KS_HALF:   if (ixp_wr_i) st_d = (wdata_i == KEY_OPEN) ? KS_OPEN : KS_CLOSED;
      KS_OPEN:   if (ixp_wr_i && (wdata_i == KEY_CLOSE)) st_d = KS_CLOSED;
      default:   st_d = KS_CLOSED;
    endcase
  end

  always_comb begin
    index_en = (st_q == KS_OPEN) && ixp_wr_i && (wdata_i != KEY_CLOSE);
    index_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= KS_CLOSED;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
    end else if (index_en) begin
      index_q <= index_d;
    end
  end

  assign open_o  = (st_q == KS_OPEN);
  assign index_o = index_q;

endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h5A31,
  parameter logic [7:0]  CHIP_REV = 8'h07,
  parameter logic [15:0] MAKER_ID = 16'hC3D1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_wr_t           wr_i,
  input  logic [BYTE_W-1:0] rd_idx_i,
  output logic [BYTE_W-1:0] devnum_o,
  output logic [BYTE_W-1:0] rdata_o
);

  logic [BYTE_W-1:0] devnum_q, devnum_d;
  logic              devnum_en;

  always_comb begin
    devnum_en = wr_i.wr && (wr_i.idx == IX_DEVNUM);
    devnum_d  = wr_i.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devnum_q <= '0;
    end else if (devnum_en) begin
      devnum_q <= devnum_d;
    end
  end

  always_comb begin
    unique case (rd_idx_i)
      IX_DEVNUM:   rdata_o = devnum_q;
      IX_CHIP_HI:  rdata_o = CHIP_ID[15:8];
      IX_CHIP_LO:  rdata_o = CHIP_ID[7:0];
      IX_REV:      rdata_o = CHIP_REV;
      IX_MAKER_HI: rdata_o = MAKER_ID[15:8];
      IX_MAKER_LO: rdata_o = MAKER_ID[7:0];
      default:     rdata_o = '0;
    endcase
  end

  assign devnum_o = devnum_q;

endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  cfg_wr_t           wr_i,
  input  logic [BYTE_W-1:0] rd_idx_i,
  output logic              act_o,
  output logic [IOA_W-1:0]  iob_o,
  output logic [BYTE_W-1:0] rdata_o
);

  logic              act_q, act_d, act_en;
  logic [BYTE_W-1:0] iob_hi_q, iob_lo_q;
  logic              hi_en, lo_en;
  logic              bank_wr;

  always_comb begin
    bank_wr = wr_i.wr && sel_i;
    act_en  = bank_wr && (wr_i.idx == IX_ACT);
    hi_en   = bank_wr && (wr_i.idx == IX_IOB_HI);
    lo_en   = bank_wr && (wr_i.idx == IX_IOB_LO);
    act_d   = wr_i.data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iob_hi_q <= '0;
    end else if (hi_en) begin
      iob_hi_q <= wr_i.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iob_lo_q <= '0;
    end else if (lo_en) begin
      iob_lo_q <= wr_i.data;
    end
  end

  always_comb begin
    unique case (rd_idx_i)
      IX_ACT:    rdata_o = {7'b0, act_q};
      IX_IOB_HI: rdata_o = iob_hi_q;
      IX_IOB_LO: rdata_o = iob_lo_q;
      default:   rdata_o = '0;
    endcase
  end

  assign act_o = act_q;
  assign iob_o = {iob_hi_q, iob_lo_q};

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned NUM_DEV  = 8,
  parameter logic [15:0] CHIP_ID  = 16'h5A31,
  parameter logic [7:0]  CHIP_REV = 8'h07,
  parameter logic [15:0] MAKER_ID = 16'hC3D1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_base_sel,
  input  logic [15:0]              io_addr,
  input  logic                     io_wr,
  input  logic                     io_rd,
  input  logic [7:0]               io_wdata,
  output logic [7:0]               io_rdata,
  output logic [NUM_DEV-1:0]       dev_enable,
  output logic [NUM_DEV*16-1:0]    dev_base
);

  localparam int unsigned BASE_ALL_W = NUM_DEV * IOA_W;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  // port decode
  logic [IOA_W-1:0] ixp_addr, dtp_addr;
  logic             hit_ixp, hit_dtp;
  logic             ixp_wr, dtp_wr;
  logic             cfg_open;
  logic [BYTE_W-1:0] cur_index;

  always_comb begin
    ixp_addr = port_base(cfg_base_sel);
    dtp_addr = ixp_addr + 16'd1;
    hit_ixp  = (io_addr == ixp_addr);
    hit_dtp  = (io_addr == dtp_addr);
    ixp_wr   = io_wr && hit_ixp;
    dtp_wr   = io_wr && hit_dtp && cfg_open;
  end

  sio_key_fsm key_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ixp_wr_i (ixp_wr),
    .wdata_i  (io_wdata),
    .open_o   (cfg_open),
    .index_o  (cur_index)
  );

  // write routing
  cfg_wr_t glob_wr, bank_wr;
  logic    idx_is_bank;

  always_comb begin
    idx_is_bank  = (cur_index >= IX_BANK_LO);
    glob_wr.wr   = dtp_wr && !idx_is_bank;
    glob_wr.idx  = cur_index;
    glob_wr.data = io_wdata;
    bank_wr.wr   = dtp_wr && idx_is_bank;
    bank_wr.idx  = cur_index;
    bank_wr.data = io_wdata;
  end

  logic [BYTE_W-1:0] devnum;
  logic [BYTE_W-1:0] glob_rdata;

  sio_global_regs #(
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV),
    .MAKER_ID (MAKER_ID)
  ) glob_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_i     (glob_wr),
    .rd_idx_i (cur_index),
    .devnum_o (devnum),
    .rdata_o  (glob_rdata)
  );

  // one bank per logical device
  logic [NUM_DEV-1:0]    bank_sel;
  logic [BYTE_W-1:0]     bank_rd [NUM_DEV];
  logic [BASE_ALL_W-1:0] base_all;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    assign bank_sel[g] = (devnum == BYTE_W'(g));

    sio_ldev_bank bank_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .sel_i    (bank_sel[g]),
      .wr_i     (bank_wr),
      .rd_idx_i (cur_index),
      .act_o    (dev_enable[g]),
      .iob_o    (base_all[g*IOA_W +: IOA_W]),
      .rdata_o  (bank_rd[g])
    );
  end

  assign dev_base = base_all;

  // read mux
  logic [BYTE_W-1:0] bank_rdata;

  always_comb begin
    bank_rdata = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (bank_sel[i]) bank_rdata = bank_rdata | bank_rd[i];
    end
  end

  always_comb begin
    if (!cfg_open || !(hit_ixp || hit_dtp)) begin
      io_rdata = FLOAT_BYTE;
    end else if (hit_ixp) begin
      io_rdata = cur_index;
    end else if (idx_is_bank) begin
      io_rdata = bank_rdata;
    end else begin
      io_rdata = glob_rdata;
    end
  end

  // io_rd only qualifies the access on the bus; reads have no side effect
  logic unused_rd;
  assign unused_rd = io_rd;

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
  import sio_cfg_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_base_sel,
  input logic [15:0]           io_addr,
  input logic                  io_wr,
  input logic                  io_rd,
  input logic [7:0]            io_wdata,
  input logic [7:0]            io_rdata,
  input logic [NUM_DEV-1:0]    dev_enable,
  input logic [NUM_DEV*16-1:0] dev_base,
  input logic                  cfg_open
);

  logic [15:0] ixp, dtp;
  logic        at_ixp, at_dtp;

  always_comb begin
    ixp    = cfg_base_sel ? 16'h004E : 16'h002E;
    dtp    = ixp + 16'd1;
    at_ixp = (io_addr == ixp);
    at_dtp = (io_addr == dtp);
  end

  // R3: closed space reads back as floating bus
  a_r3_closed_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd && (at_ixp || at_dtp)) |-> (io_rdata == 8'hFF));

  // R3: no bank register moves in a cycle that started closed
  a_r3_closed_banks_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_open) |-> ($stable(dev_enable) && $stable(dev_base)));

  // R2: opening is always caused by a key byte at the index port
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && !$past(cfg_open)) |->
      ($past(io_wr) && $past(at_ixp) && ($past(io_wdata) == 8'h87)));

  // R4: close key shuts the space on the next edge
  a_r4_close_key: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && at_ixp && (io_wdata == 8'hAA)) |=> !cfg_open);

  // R5: foreign addresses read as floating bus
  a_r5_foreign_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !at_ixp && !at_dtp) |-> (io_rdata == 8'hFF));

  // R8: one data write touches at most one device activation bit
  a_r8_single_act_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dev_enable ^ $past(dev_enable)) <= 1);

endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NUM_DEV(NUM_DEV)) chk_i (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .cfg_base_sel (cfg_base_sel),
  .io_addr      (io_addr),
  .io_wr        (io_wr),
  .io_rd        (io_rd),
  .io_wdata     (io_wdata),
  .io_rdata     (io_rdata),
  .dev_enable   (dev_enable),
  .dev_base     (dev_base),
  .cfg_open     (cfg_open)
);

// File: tb/sio_cfg_port_tb_top.sv
`timescale 1ns/1ps
module sio_cfg_port_tb_top;

  localparam int unsigned NDEV  = 4;
  localparam logic [15:0] T_CHIP  = 16'h5A31;
  localparam logic [7:0]  T_REV   = 8'h07;
  localparam logic [15:0] T_MAKER = 16'hC3D1;

  logic                 clk;
  logic                 rst_n;
  logic                 cfg_base_sel;
  logic [15:0]          io_addr;
  logic                 io_wr;
  logic                 io_rd;
  logic [7:0]           io_wdata;
  logic [7:0]           io_rdata;
  logic [NDEV-1:0]      dev_enable;
  logic [NDEV*16-1:0]   dev_base;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  sio_cfg_port #(
    .NUM_DEV  (NDEV),
    .CHIP_ID  (T_CHIP),
    .CHIP_REV (T_REV),
    .MAKER_ID (T_MAKER)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_base_sel (cfg_base_sel),
    .io_addr      (io_addr),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .dev_enable   (dev_enable),
    .dev_base     (dev_base)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  // driver: pushes the expected byte, monitor compares it
  task automatic rd(logic [15:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(logic [15:0] b, logic [7:0] ix, logic [7:0] d);
    wr(b, ix);
    wr(b + 16'd1, d);
  endtask

  task automatic reg_rd(logic [15:0] b, logic [7:0] ix, logic [7:0] e, string tag);
    wr(b, ix);
    rd(b + 16'd1, e, tag);
  endtask

  task automatic do_reset(logic strap);
    rst_n = 1'b0; io_wr = 1'b0; io_rd = 1'b0; io_addr = '0; io_wdata = '0;
    cfg_base_sel = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // monitor: samples away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (io_rd) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL monitor: unexpected read actual=%0h expected=none", io_rdata);
        end else begin
          check(tag_q.pop_front(), {56'd0, io_rdata}, {56'd0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    // R1 reset state
    check("R1 enables after reset", {60'd0, dev_enable}, 64'd0);
    check("R1 bases after reset", dev_base, 64'd0);
    rd(16'h002F, 8'hFF, "R1 data port closed after reset");
    rd(16'h002E, 8'hFF, "R3 index port closed");

    // R3 closed writes are dropped
    wr(16'h002E, 8'h30);
    wr(16'h002F, 8'h01);
    check("R3 closed write no enable", {60'd0, dev_enable}, 64'd0);

    // R2 broken key stays closed
    wr(16'h002E, 8'h87);
    wr(16'h002E, 8'h11);
    wr(16'h002E, 8'h87);
    rd(16'h002E, 8'hFF, "R2 broken key keeps closed");
    // data-port access between key bytes does not disturb
    rd(16'h002F, 8'hFF, "R3 closed data read");
    wr(16'h002E, 8'h87);
    rd(16'h002E, 8'h00, "R2 opened, index untouched by key (R11)");

    // R6 identification
    reg_rd(16'h002E, 8'h20, T_CHIP[15:8], "R6 chip id high");
    reg_rd(16'h002E, 8'h21, T_CHIP[7:0], "R6 chip id low");
    reg_rd(16'h002E, 8'h22, T_REV, "R6 revision");
    reg_rd(16'h002E, 8'h23, T_MAKER[15:8], "R6 maker high");
    reg_rd(16'h002E, 8'h24, T_MAKER[7:0], "R6 maker low");
    reg_wr(16'h002E, 8'h20, 8'h00);
    reg_rd(16'h002E, 8'h20, T_CHIP[15:8], "R6 id read-only");
    rd(16'h002E, 8'h20, "R11 index port returns latch");
    reg_rd(16'h002E, 8'h25, 8'h00, "R10 unimplemented global");

    // R7 device number
    reg_wr(16'h002E, 8'h07, 8'h02);
    reg_rd(16'h002E, 8'h07, 8'h02, "R7 device number readback");

    // R8 activation of device 2
    reg_wr(16'h002E, 8'h30, 8'hFF);
    reg_rd(16'h002E, 8'h30, 8'h01, "R8 only bit 0 kept");
    check("R8 enable output dev2", {60'd0, dev_enable}, 64'h4);

    // R9 base address of device 2
    reg_wr(16'h002E, 8'h60, 8'h12);
    reg_wr(16'h002E, 8'h61, 8'h34);
    reg_rd(16'h002E, 8'h60, 8'h12, "R9 base high");
    reg_rd(16'h002E, 8'h61, 8'h34, "R9 base low");
    check("R9 base output dev2", dev_base, 64'h0000_1234_0000_0000);

    // R7 bank separation
    reg_wr(16'h002E, 8'h07, 8'h01);
    reg_rd(16'h002E, 8'h30, 8'h00, "R7 dev1 bank separate");
    reg_rd(16'h002E, 8'h60, 8'h00, "R7 dev1 base separate");
    reg_wr(16'h002E, 8'h30, 8'h01);
    check("R8 enable output dev1+dev2", {60'd0, dev_enable}, 64'h6);
    reg_rd(16'h002E, 8'h22, T_REV, "R10 global ignores device number");

    // R10 device number out of range
    reg_wr(16'h002E, 8'h07, 8'h05);
    reg_wr(16'h002E, 8'h30, 8'h01);
    reg_wr(16'h002E, 8'h60, 8'hEE);
    reg_rd(16'h002E, 8'h30, 8'h00, "R10 out-of-range bank reads 0");
    check("R10 out-of-range write ignored", {60'd0, dev_enable}, 64'h6);
    check("R10 out-of-range base ignored", dev_base, 64'h0000_1234_0000_0000);

    reg_wr(16'h002E, 8'h07, 8'h02);
    reg_rd(16'h002E, 8'h61, 8'h34, "R7 dev2 kept its base");

    // R5 foreign address
    wr(16'h004F, 8'h00);
    rd(16'h004F, 8'hFF, "R5 foreign address reads FF");
    reg_rd(16'h002E, 8'h30, 8'h01, "R5 foreign write ignored");

    // R4 close key, 0x87 while open just loads index
    wr(16'h002E, 8'h87);
    rd(16'h002E, 8'h87, "R4 non-close byte loads index");
    wr(16'h002E, 8'hAA);
    rd(16'h002F, 8'hFF, "R4 closed after AA");
    rd(16'h002E, 8'hFF, "R4 index port closed after AA");
    wr(16'h002F, 8'h00);
    check("R4 write after close ignored", {60'd0, dev_enable}, 64'h6);
    wr(16'h002E, 8'h87);
    wr(16'h002E, 8'h87);
    rd(16'h002E, 8'h87, "R4 index latch kept across close");

    // R5 alternate base
    do_reset(1'b1);
    check("R1 enables cleared by reset", {60'd0, dev_enable}, 64'd0);
    wr(16'h002E, 8'h87);
    wr(16'h002E, 8'h87);
    rd(16'h004E, 8'hFF, "R5 key at low base ignored when strap=1");
    wr(16'h004E, 8'h87);
    wr(16'h004E, 8'h87);
    reg_wr(16'h004E, 8'h07, 8'h03);
    reg_rd(16'h004E, 8'h07, 8'h03, "R5 high base access");
    rd(16'h002F, 8'hFF, "R5 low data port dead when strap=1");
    reg_wr(16'h004E, 8'h30, 8'h01);
    check("R8 enable output dev3", {60'd0, dev_enable}, 64'h8);

    repeat (4) @(negedge clk);
    done = 1'b1;
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL monitor: actual=%0d pending expected=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule